// File: doc/BRIEF.md
# Shared-Cache Home Bank Locator with Distance-Based Latency

This block sits in front of a last-level cache that is shared by every tile of a square mesh and split into one bank per tile. A core hands it a request carrying its own tile number, a physical address and a transaction number. The block works out which tile's bank is home to the addressed block and which set inside that bank holds it. It counts the mesh hops between the requesting tile and the home tile, and it holds the request for the access time that follows from that distance. It then returns a completion tagged with the transaction number and the requester.

Two mapping modes are available. In block-interleaved mode the tile field sits just above the block offset, so neighbouring blocks go to neighbouring tiles. In page-colored mode every block of a physical page lands in one tile, chosen by the page number. Up to eight requests can be in flight at once, and each one is timed independently. The block models where data lives and how long it takes to reach it. It holds no cache data and does no routing.

Top module: `nuca_home_mapper`

## Requirements
- R1: With `map_mode` = 0 (block-interleaved, 64-byte blocks, 16 tiles), the home tile is address bits [9:6] and the set index is address bits [19:10].
- R2: With `map_mode` = 1 (page-colored, 4 KB pages), the home tile is the page number modulo 16, which is address bits [15:12]. The set index is address bits [15:6]. The mode is changed only while no request is outstanding.
- R3: Tiles are numbered row-major on a 4×4 mesh, so tile t sits in row t/4 and column t%4. The hop count is |Δrow| + |Δcol|, and the access latency is 10 + 4 × hops cycles. A local access takes 10 cycles and tile 0 to tile 15 takes 34. A request accepted in cycle c completes in cycle c + latency, unless it is delayed by R6.
- R4: A completion carries the request's transaction number, its requester tile, the computed home tile and the computed set index.
- R5: At most 8 requests are outstanding. `req_ready` is low exactly while all 8 are in flight, and it rises in the cycle after a completion frees a slot.
- R6: A new request takes the lowest-numbered free slot. When several slots expire in the same cycle, the lowest-numbered one completes first and each of the others waits one more cycle per slot ahead of it.
- R7: In the first cycle after reset, `req_ready` is 1 and `cpl_valid` is 0.
- R8: Every accepted request produces exactly one single-cycle completion, and at most one completion is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_mode | input | 1 | 0 selects block-interleaved mapping, 1 selects page-colored mapping |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | A slot is free; the request is accepted when valid and ready are both high |
| req_src | input | 4 | Requesting tile |
| req_addr | input | 32 | Physical address |
| req_txn | input | 4 | Transaction number |
| cpl_valid | output | 1 | Completion pulse |
| cpl_txn | output | 4 | Transaction number of the completed request |
| cpl_src | output | 4 | Requester tile of the completed request |
| cpl_home | output | 4 | Home tile of the completed request |
| cpl_set | output | 10 | Set index inside the home bank |

## Verification
The bench measures latency to the exact cycle for local, corner-to-corner and mid-mesh requests, so an off-by-one counter load or a wrong hop formula shows up as a shifted completion. It runs the same style of address through both mapping modes, so a design that decodes the wrong bit field, or ignores the mode, reports the wrong home tile or set. Two requests are staged to expire in the same cycle, so a design that drops one of them or picks the wrong one first gives the wrong completion order. The bench also fills all eight slots, so a design that lowers `req_ready` too late, too early, or keeps it low too long is caught at the cycle where the first slot frees.

// File: rtl/nuca_pkg.sv
package nuca_pkg;

    localparam int ADDR_W    = 32;
    localparam int OFF_W     = 6;
    localparam int SET_W     = 10;
    localparam int MESH_DIM  = 4;
    localparam int PAGE_W    = 12;
    localparam int SLOTS     = 8;
    localparam int TXN_W     = 4;
    localparam int BANK_CYC  = 10;
    localparam int HOP_CYC   = 2;

    localparam int TILES     = MESH_DIM * MESH_DIM;
    localparam int TILE_W    = $clog2(TILES);
    localparam int AXIS_W    = $clog2(MESH_DIM);
    localparam int MAX_HOPS  = 2 * (MESH_DIM - 1);
    localparam int HOP_W     = $clog2(MAX_HOPS + 1);
    localparam int MAX_LAT   = BANK_CYC + 2 * HOP_CYC * MAX_HOPS;
    localparam int LAT_W     = $clog2(MAX_LAT + 1);
    localparam int SLOT_W    = $clog2(SLOTS);

    typedef enum logic {
        MAP_BLOCK = 1'b0,
        MAP_PAGE  = 1'b1
    } map_mode_e;

    typedef logic [TILE_W-1:0] tile_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [TXN_W-1:0]  txn_t;
    typedef logic [LAT_W-1:0]  lat_t;

    typedef struct packed {
        txn_t  txn;
        tile_t src;
        tile_t home;
        set_t  set_idx;
    } req_info_t;

    function automatic logic [AXIS_W-1:0] tile_row(input tile_t t);
        return t[TILE_W-1:AXIS_W];
    endfunction

    function automatic logic [AXIS_W-1:0] tile_col(input tile_t t);
        return t[AXIS_W-1:0];
    endfunction

    function automatic logic [AXIS_W-1:0] axis_dist(input logic [AXIS_W-1:0] a,
                                                    input logic [AXIS_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/nuca_addr_map.sv
module nuca_addr_map
    import nuca_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int OW    = OFF_W,
    parameter int SW    = SET_W,
    parameter int TW    = TILE_W,
    parameter int PW    = PAGE_W
) (
    input  logic          mode,
    input  logic [AW-1:0] addr,
    output logic [TW-1:0] home,
    output logic [SW-1:0] set_idx
);

    localparam int BLK_TILE_LSB = OW;
    localparam int BLK_SET_LSB  = OW + TW;
    localparam int PG_TILE_LSB  = PW;
    localparam int PG_SET_LSB   = OW;

    logic [TW-1:0] blk_home;
    logic [SW-1:0] blk_set;
    logic [TW-1:0] pg_home;
    logic [SW-1:0] pg_set;

    // Block-interleaved: tile bits sit directly above the block offset.
    assign blk_home = addr[BLK_TILE_LSB +: TW];
    assign blk_set  = addr[BLK_SET_LSB  +: SW];

    // Page-colored: tile count is a power of two, so the modulo keeps the
    // low bits of the page number.
    assign pg_home  = addr[PG_TILE_LSB +: TW];
    assign pg_set   = addr[PG_SET_LSB  +: SW];

    always_comb begin
        if (map_mode_e'(mode) == MAP_PAGE) begin
            home    = pg_home;
            set_idx = pg_set;
        end else begin
            home    = blk_home;
            set_idx = blk_set;
        end
    end

endmodule

// File: rtl/nuca_hop_calc.sv
module nuca_hop_calc
    import nuca_pkg::*;
#(
    parameter int BANK = BANK_CYC,
    parameter int HOP  = HOP_CYC
) (
    input  tile_t src,
    input  tile_t dst,
    output logic [HOP_W-1:0] hops,
    output lat_t  latency
);

    logic [AXIS_W-1:0] d_row;
    logic [AXIS_W-1:0] d_col;

    always_comb begin
        d_row   = axis_dist(tile_row(src), tile_row(dst));
        d_col   = axis_dist(tile_col(src), tile_col(dst));
        hops    = HOP_W'(d_row) + HOP_W'(d_col);
        // Hops are paid once on the way out and once on the way back.
        latency = LAT_W'(BANK) + LAT_W'(2 * HOP) * LAT_W'(hops);
    end

endmodule

// File: rtl/nuca_slot_pool.sv
module nuca_slot_pool
    import nuca_pkg::*;
#(
    parameter int N  = SLOTS,
    parameter int NW = SLOT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      alloc,
    input  req_info_t alloc_info,
    input  lat_t      alloc_lat,
    output logic      all_busy,
    output logic      out_valid,
    output req_info_t out_info
);

    logic      busy_q [N];
    lat_t      cnt_q  [N];
    req_info_t info_q [N];

    logic [N-1:0]  expired;
    logic [N-1:0]  busy_vec;
    logic [NW-1:0] free_idx;
    logic [NW-1:0] sel_idx;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            busy_vec[i] = busy_q[i];
            expired[i]  = busy_q[i] && (cnt_q[i] == '0);
        end
    end

    assign all_busy  = &busy_vec;
    assign out_valid = |expired;

    // Lowest free slot for allocation, lowest expired slot for return.
    always_comb begin
        free_idx = '0;
        sel_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy_vec[i]) free_idx = NW'(i);
            if (expired[i])   sel_idx  = NW'(i);
        end
    end

    assign out_info = info_q[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                busy_q[i] <= 1'b0;
                cnt_q[i]  <= '0;
                info_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (out_valid && (sel_idx == NW'(i))) begin
                    busy_q[i] <= 1'b0;
                end else if (alloc && !busy_q[i] && (free_idx == NW'(i))) begin
                    busy_q[i] <= 1'b1;
                    cnt_q[i]  <= alloc_lat - lat_t'(1);
                    info_q[i] <= alloc_info;
                end else if (busy_q[i] && (cnt_q[i] != '0)) begin
                    cnt_q[i]  <= cnt_q[i] - lat_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/nuca_home_mapper.sv
module nuca_home_mapper
    import nuca_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              map_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TILE_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TXN_W-1:0]  req_txn,
    output logic              cpl_valid,
    output logic [TXN_W-1:0]  cpl_txn,
    output logic [TILE_W-1:0] cpl_src,
    output logic [TILE_W-1:0] cpl_home,
    output logic [SET_W-1:0]  cpl_set
);

    tile_t            home;
    set_t             set_idx;
    logic [HOP_W-1:0] hops;
    lat_t             latency;
    logic             all_busy;
    logic             accept;
    req_info_t        new_info;
    req_info_t        done_info;

    nuca_addr_map u_map (
        .mode    (map_mode),
        .addr    (req_addr),
        .home    (home),
        .set_idx (set_idx)
    );

    nuca_hop_calc u_hops (
        .src     (req_src),
        .dst     (home),
        .hops    (hops),
        .latency (latency)
    );

    assign req_ready = !all_busy;
    assign accept    = req_valid && req_ready;

    always_comb begin
        new_info.txn     = req_txn;
        new_info.src     = req_src;
        new_info.home    = home;
        new_info.set_idx = set_idx;
    end

    nuca_slot_pool u_pool (
        .clk        (clk),
        .rst        (rst),
        .alloc      (accept),
        .alloc_info (new_info),
        .alloc_lat  (latency),
        .all_busy   (all_busy),
        .out_valid  (cpl_valid),
        .out_info   (done_info)
    );

    assign cpl_txn  = done_info.txn;
    assign cpl_src  = done_info.src;
    assign cpl_home = done_info.home;
    assign cpl_set  = done_info.set_idx;

endmodule

// File: rtl/nuca_home_mapper_chk.sv
module nuca_home_mapper_chk
    import nuca_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic map_mode,
    input logic req_valid,
    input logic req_ready,
    input logic cpl_valid
);

    logic [SLOT_W:0] inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_q
                        + (SLOT_W+1)'(req_valid && req_ready)
                        - (SLOT_W+1)'(cpl_valid);
        end
    end

    AST_READY_TRACKS_ROOM: assert property (@(posedge clk) disable iff (rst)
        req_ready == (inflight_q < (SLOT_W+1)'(SLOTS))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        inflight_q <= (SLOT_W+1)'(SLOTS)); // R5

    AST_CPL_HAS_OWNER: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (inflight_q != '0)); // R8

    AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !cpl_valid)); // R7

    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (inflight_q != '0) |-> $stable(map_mode)); // R2

endmodule

bind nuca_home_mapper nuca_home_mapper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .map_mode  (map_mode),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cpl_valid (cpl_valid)
);

// File: tb/nuca_home_mapper_tb.sv
module nuca_home_mapper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_src = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_txn = '0;
    logic        cpl_valid;
    logic [3:0]  cpl_txn;
    logic [3:0]  cpl_src;
    logic [3:0]  cpl_home;
    logic [9:0]  cpl_set;

    always #5 clk = ~clk;

    nuca_home_mapper u_dut (
        .clk       (clk),
        .rst       (rst),
        .map_mode  (map_mode),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_src   (req_src),
        .req_addr  (req_addr),
        .req_txn   (req_txn),
        .cpl_valid (cpl_valid),
        .cpl_txn   (cpl_txn),
        .cpl_src   (cpl_src),
        .cpl_home  (cpl_home),
        .cpl_set   (cpl_set)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected and observed records per transaction number.
    int acc_cyc [16];
    int e_src [16], e_home [16], e_set [16], e_lat [16];
    bit got [16];
    int seen [16];
    int g_cyc [16], g_src [16], g_home [16], g_set [16];

    always @(negedge clk) begin
        if (!rst && cpl_valid) begin
            got[cpl_txn]    = 1'b1;
            seen[cpl_txn]   = seen[cpl_txn] + 1;
            g_cyc[cpl_txn]  = cyc;
            g_src[cpl_txn]  = cpl_src;
            g_home[cpl_txn] = cpl_home;
            g_set[cpl_txn]  = cpl_set;
        end
    end

    function automatic int exp_home(input bit m, input logic [31:0] a);
        return m ? int'(a[15:12]) : int'(a[9:6]);
    endfunction

    function automatic int exp_set(input bit m, input logic [31:0] a);
        return m ? int'(a[15:6]) : int'(a[19:10]);
    endfunction

    function automatic int exp_lat(input int s, input int h);
        int dr, dc;
        dr = (s / 4) - (h / 4);
        dc = (s % 4) - (h % 4);
        if (dr < 0) dr = -dr;
        if (dc < 0) dc = -dc;
        return 10 + 4 * (dr + dc);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge with valid low.
    task automatic send(input int src, input logic [31:0] addr, input int txn);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_src   = 4'(src);
        req_addr  = addr;
        req_txn   = 4'(txn);
        acc_cyc[txn] = cyc;
        e_src[txn]   = src;
        e_home[txn]  = exp_home(map_mode, addr);
        e_set[txn]   = exp_set(map_mode, addr);
        e_lat[txn]   = exp_lat(src, e_home[txn]);
        got[txn]     = 1'b0;
        seen[txn]    = 0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_got(input int txn);
        for (int i = 0; i < 80 && !got[txn]; i++) @(negedge clk);
        #1;
    endtask

    task automatic verify(input int txn, input string rq);
        wait_got(txn);
        check(got[txn], {rq, " completion present"}, got[txn], 1);
        check(g_cyc[txn] - acc_cyc[txn] == e_lat[txn], "R3 latency",
              g_cyc[txn] - acc_cyc[txn], e_lat[txn]);
        check(g_home[txn] == e_home[txn], {rq, " home tile"}, g_home[txn], e_home[txn]);
        check(g_set[txn] == e_set[txn], {rq, " set index"}, g_set[txn], e_set[txn]);
        check(g_src[txn] == e_src[txn], "R4 requester", g_src[txn], e_src[txn]);
    endtask

    task automatic drain();
        repeat (45) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R7 ready after reset", req_ready, 1);
        check(cpl_valid == 1'b0, "R7 no completion after reset", cpl_valid, 0);
    endtask

    task automatic t_block();
        map_mode = 1'b0;
        @(negedge clk);
        send(0, 32'h0000_0000, 1);   // local, 10 cycles
        verify(1, "R1");
        @(negedge clk);
        send(0, 32'h0000_03C0, 2);   // tile 15, 6 hops, 34 cycles
        verify(2, "R1");
        @(negedge clk);
        send(6, 32'hDEAD_BEEF, 3);
        verify(3, "R1");
        @(negedge clk);
        send(9, 32'h000F_FC40, 4);
        verify(4, "R1");
        check(seen[4] == 1, "R8 single completion", seen[4], 1);
    endtask

    task automatic t_page();
        drain();
        map_mode = 1'b1;
        @(negedge clk);
        send(5, 32'h0000_7ABC, 5);
        verify(5, "R2");
        @(negedge clk);
        send(10, 32'h1234_F040, 6);
        verify(6, "R2");
        @(negedge clk);
        send(15, 32'h0000_03C0, 7);  // same bits that gave tile 15 in block mode
        verify(7, "R2");
        drain();
        map_mode = 1'b0;
    endtask

    task automatic t_tie();
        drain();
        @(negedge clk);
        send(0, 32'h0000_0440, 10);  // slot 0, one hop, 14 cycles
        repeat (3) @(negedge clk);
        send(0, 32'h0000_0800, 11);  // slot 1, local, expires the same cycle
        wait_got(10);
        wait_got(11);
        check(g_cyc[10] - acc_cyc[10] == 14, "R6 lower slot first",
              g_cyc[10] - acc_cyc[10], 14);
        check(g_cyc[11] - acc_cyc[11] == 11, "R6 higher slot one cycle later",
              g_cyc[11] - acc_cyc[11], 11);
        check(g_home[11] == e_home[11] && g_set[11] == e_set[11],
              "R6 held completion fields", g_set[11], e_set[11]);
        check(seen[10] == 1 && seen[11] == 1, "R8 one completion each",
              seen[10] + seen[11], 2);
    endtask

    task automatic t_full();
        int c0;
        drain();
        @(negedge clk);
        for (int k = 0; k < 8; k++) send(0, 32'h0000_03C0 + 32'(k) * 32'h400, k);
        c0 = acc_cyc[0];
        check(req_ready == 1'b0, "R5 ready low when full", req_ready, 0);
        while (cyc < c0 + 34) @(negedge clk);
        check(req_ready == 1'b0, "R5 ready low in freeing cycle", req_ready, 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R5 ready back after free", req_ready, 1);
        send(15, 32'h0000_03C0, 8);
        for (int k = 0; k < 9; k++) verify(k, "R5");
        drain();
        for (int k = 0; k < 9; k++)
            check(seen[k] == 1, "R8 exactly one completion", seen[k], 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_block();
        t_page();
        t_tie();
        t_full();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule